// File: doc/BRIEF.md
# None-Some-Many Test Response Classifier

This block rates one test circuit, built from a chain of reconfigurable components, as holding no defects, some defects or many defects. Three response streams arrive from the fabric under test. The long check (a) watches the whole chain. The two short checks (b) and (c) each watch one part of the same chain after it is split. Each stream is compacted into a signature by its own linear feedback shift register, and each signature is then compared for equality with a golden value. The three pass/fail results are reduced by a fixed decision order to a 2-bit class code.

Software or a sequencer sets the run length and the three golden signatures, then pulses `start_i`. The response words come over one shared valid/ready channel. Each beat carries one word for each of the three checks. After the set number of beats, the block compares the signatures, publishes the class and pulses `done_o`. `beat_ready_o` is high only while a run is collecting beats. A beat presented while ready is low is neither taken nor stored, and the producer has to hold it until ready is high. Once a beat is offered, `beat_valid_i` may drop only after the beat has been taken.

Top module: `nsm_classifier`

## Requirements
- R1: After reset, `class_o` is 2'b00, and `done_o`, `busy_o` and `beat_ready_o` are all low.
- R2: A `start_i` sampled high while `busy_o` is low starts a run. From the next cycle, `busy_o` and `beat_ready_o` are both high. The run length `run_len_i` and the zero seed of all three signatures are taken at that edge.
- R3: A beat is taken only on a clock edge where `beat_valid_i` and `beat_ready_o` are both high. For each check, the signature S (SIG_W bits, seed 0) is updated as S' = (S << 1) ^ (S[MSB] ? POLY : 0) ^ word, where POLY defaults to 16'h1021.
- R4: A run collects exactly `run_len_i` beats, and a length of zero counts as one. `beat_ready_o` goes low in the cycle after the last beat is taken.
- R5: If signature (a) equals `gold_a_i`, the class is none (2'b00), whatever (b) and (c) give.
- R6: If (a) mismatches and at most one of (b) and (c) mismatches, the class is some (2'b01).
- R7: If (a), (b) and (c) all mismatch, the class is many (2'b10).
- R8: `class_o` never shows 2'b11.
- R9: `done_o` is high for exactly one cycle, starting after the second clock edge that follows the last beat taken. `class_o` takes its new value at the same edge and keeps it until the next `done_o`.
- R10: A `start_i` pulse during a run has no effect: the run keeps its length and signatures, and gives the same class.
- R11: `beat_ready_o` is low whenever no run is collecting beats. Beats offered at such times do not change the result of the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run; ignored while busy |
| run_len_i | input | LEN_W | Number of beats in the run (0 counts as 1) |
| busy_o | output | 1 | A run is in progress |
| beat_valid_i | input | 1 | Response beat offered |
| beat_ready_o | output | 1 | Block takes the beat at this edge |
| beat_a_i | input | SIG_W | Response word of the full-chain check |
| beat_b_i | input | SIG_W | Response word of the first sub-check |
| beat_c_i | input | SIG_W | Response word of the second sub-check |
| gold_a_i | input | SIG_W | Expected signature of the full-chain check |
| gold_b_i | input | SIG_W | Expected signature of the first sub-check |
| gold_c_i | input | SIG_W | Expected signature of the second sub-check |
| class_o | output | 2 | 00 none, 01 some, 10 many |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The assertions check on every cycle the shape of the handshake and of the result strobe: ready never high outside a busy period, a one-cycle done at the fixed distance from the end of collection, an accepted start opening collection, a legal class code, and a class that changes only with done. The signature arithmetic, the mapping from each of the eight pass/fail combinations to a class, the counting of beats through stalls, and the immunity to a second start or to beats offered while idle show up only in the bench's scenarios. The bench computes the expected signatures itself from the update rule.

// File: rtl/nsm_pkg.sv
package nsm_pkg;
  typedef enum logic [1:0] {
    CLS_NONE = 2'b00,
    CLS_SOME = 2'b01,
    CLS_MANY = 2'b10
  } nsm_class_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_CMP,
    ST_FIN
  } nsm_state_e;

  // Index 0 is the full-chain check, 1 and 2 are the split sub-checks.
  localparam int NUM_CHECKS = 3;
endpackage

// File: rtl/nsm_misr.sv
module nsm_misr #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   POLY = 16'h1021
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic [W-1:0] din,
  output logic [W-1:0] sig
);
  logic [W-1:0] fb;

  always_comb begin
    fb = sig[W-1] ? POLY : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig <= '0;
    end else if (clear) begin
      sig <= '0;
    end else if (step) begin
      sig <= {sig[W-2:0], 1'b0} ^ fb ^ din;
    end
  end
endmodule

// File: rtl/nsm_seq.sv
module nsm_seq
  import nsm_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] run_len,
  input  logic             beat_valid,
  output logic             busy,
  output logic             ready,
  output logic             step,
  output logic             clear,
  output logic             cmp_en,
  output logic             fin
);
  nsm_state_e       state;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W:0]   next_cnt;
  logic             last_beat;

  always_comb begin
    busy      = (state != ST_IDLE);
    ready     = (state == ST_RUN);
    step      = ready && beat_valid;
    clear     = (state == ST_IDLE) && start;
    cmp_en    = (state == ST_CMP);
    fin       = (state == ST_FIN);
    next_cnt  = {1'b0, cnt} + 1'b1;
    last_beat = (next_cnt >= {1'b0, len_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      len_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_RUN;
          cnt   <= '0;
          len_q <= run_len;
        end
        ST_RUN: if (beat_valid) begin
          cnt <= next_cnt[LEN_W-1:0];
          if (last_beat) state <= ST_CMP;
        end
        ST_CMP:  state <= ST_FIN;
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nsm_decide.sv
module nsm_decide
  import nsm_pkg::*;
(
  input  logic       pass_full,
  input  logic [1:0] pass_part,
  output nsm_class_e cls
);
  logic [1:0] part_fails;

  always_comb begin
    part_fails = 2'(!pass_part[0]) + 2'(!pass_part[1]);
    if (pass_full)            cls = CLS_NONE;
    else if (part_fails == 2) cls = CLS_MANY;
    else                      cls = CLS_SOME;
  end
endmodule

// File: rtl/nsm_classifier.sv
module nsm_classifier
  import nsm_pkg::*;
#(
  parameter int               SIG_W = 16,
  parameter int               LEN_W = 8,
  parameter logic [SIG_W-1:0] POLY  = 16'h1021
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] run_len_i,
  output logic             busy_o,
  input  logic             beat_valid_i,
  output logic             beat_ready_o,
  input  logic [SIG_W-1:0] beat_a_i,
  input  logic [SIG_W-1:0] beat_b_i,
  input  logic [SIG_W-1:0] beat_c_i,
  input  logic [SIG_W-1:0] gold_a_i,
  input  logic [SIG_W-1:0] gold_b_i,
  input  logic [SIG_W-1:0] gold_c_i,
  output logic [1:0]       class_o,
  output logic             done_o
);
  localparam int NC = NUM_CHECKS;

  logic             step, clear, cmp_en, fin;
  logic [SIG_W-1:0] beats [NC];
  logic [SIG_W-1:0] golds [NC];
  logic [SIG_W-1:0] sigs  [NC];
  logic [NC-1:0]    pass_q;
  nsm_class_e       cls_d;
  logic [1:0]       class_q;
  logic             done_q;

  always_comb begin
    beats[0] = beat_a_i;
    beats[1] = beat_b_i;
    beats[2] = beat_c_i;
    golds[0] = gold_a_i;
    golds[1] = gold_b_i;
    golds[2] = gold_c_i;
  end

  nsm_seq #(.LEN_W(LEN_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_i),
    .run_len    (run_len_i),
    .beat_valid (beat_valid_i),
    .busy       (busy_o),
    .ready      (beat_ready_o),
    .step       (step),
    .clear      (clear),
    .cmp_en     (cmp_en),
    .fin        (fin)
  );

  for (genvar i = 0; i < NC; i++) begin : g_chk
    nsm_misr #(.W(SIG_W), .POLY(POLY)) u_misr (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clear),
      .step  (step),
      .din   (beats[i]),
      .sig   (sigs[i])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pass_q[i] <= 1'b0;
      else if (cmp_en) pass_q[i] <= (sigs[i] == golds[i]);
    end
  end

  nsm_decide u_decide (
    .pass_full (pass_q[0]),
    .pass_part (pass_q[2:1]),
    .cls       (cls_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      class_q <= CLS_NONE;
      done_q  <= 1'b0;
    end else begin
      done_q <= fin;
      if (fin) class_q <= cls_d;
    end
  end

  assign class_o = class_q;
  assign done_o  = done_q;
endmodule

// File: rtl/nsm_classifier_chk.sv
module nsm_classifier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       busy_o,
  input logic       beat_ready_o,
  input logic [1:0] class_o,
  input logic       done_o
);
  p_class_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    class_o != 2'b11);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_class_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(class_o));

  p_done_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(beat_ready_o) |-> ##2 done_o);

  p_ready_in_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
    beat_ready_o |-> busy_o);

  p_start_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && beat_ready_o));
endmodule

bind nsm_classifier nsm_classifier_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .beat_ready_o (beat_ready_o),
  .class_o      (class_o),
  .done_o       (done_o)
);

// File: tb/tb_nsm_classifier.sv
module tb_nsm_classifier;
  localparam int          SIG_W = 16;
  localparam int          LEN_W = 8;
  localparam logic [15:0] POLY  = 16'h1021;

  // {fail_a, fail_b, fail_c, expected class}
  localparam logic [4:0] VEC [8] = '{
    {3'b000, 2'b00}, {3'b001, 2'b00}, {3'b010, 2'b00}, {3'b011, 2'b00},
    {3'b100, 2'b01}, {3'b101, 2'b01}, {3'b110, 2'b01}, {3'b111, 2'b10}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [LEN_W-1:0] run_len_i = '0;
  logic             busy_o, beat_ready_o, done_o;
  logic             beat_valid_i = 1'b0;
  logic [SIG_W-1:0] beat_a_i = '0, beat_b_i = '0, beat_c_i = '0;
  logic [SIG_W-1:0] gold_a_i = '0, gold_b_i = '0, gold_c_i = '0;
  logic [1:0]       class_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 0;

  always #4 clk = ~clk;

  nsm_classifier #(.SIG_W(SIG_W), .LEN_W(LEN_W), .POLY(POLY)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .run_len_i(run_len_i),
    .busy_o(busy_o), .beat_valid_i(beat_valid_i), .beat_ready_o(beat_ready_o),
    .beat_a_i(beat_a_i), .beat_b_i(beat_b_i), .beat_c_i(beat_c_i),
    .gold_a_i(gold_a_i), .gold_b_i(gold_b_i), .gold_c_i(gold_c_i),
    .class_o(class_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] word(input int ch, input int idx, input int k);
    logic [31:0] v;
    v = (32'h9E37 * (ch + 1)) ^ (idx * 32'h1357) ^ (k * 32'h0F1D) ^ (32'(k) << ch);
    return v[15:0];
  endfunction

  function automatic logic [15:0] model_sig(input int ch, input int idx, input int n);
    logic [15:0] s = '0;
    for (int k = 0; k < n; k++)
      s = {s[14:0], 1'b0} ^ (s[15] ? POLY : 16'h0) ^ word(ch, idx, k);
    return s;
  endfunction

  task automatic run_case(input int idx, input int len, input logic [2:0] fails,
                          input logic [1:0] exp_cls, input bit gaps, input bit inject);
    int n = (len == 0) ? 1 : len;
    gold_a_i = model_sig(0, idx, n) ^ {15'b0, fails[2]};
    gold_b_i = model_sig(1, idx, n) ^ {15'b0, fails[1]};
    gold_c_i = model_sig(2, idx, n) ^ {15'b0, fails[0]};
    @(negedge clk);
    start_i = 1'b1; run_len_i = LEN_W'(len);
    @(negedge clk);
    start_i = 1'b0; run_len_i = 8'd1;
    check(busy_o && beat_ready_o, "R2 busy/ready after start", {busy_o, beat_ready_o}, 3);
    for (int k = 0; k < n; k++) begin
      if (gaps && (k % 2 == 1)) begin
        beat_valid_i = 1'b0;
        beat_a_i = 16'hDEAD; beat_b_i = 16'hBEEF; beat_c_i = 16'hFACE;
        @(negedge clk);
      end
      beat_valid_i = 1'b1;
      beat_a_i = word(0, idx, k); beat_b_i = word(1, idx, k); beat_c_i = word(2, idx, k);
      if (inject && k == 1) start_i = 1'b1;   // R10 start while busy
      @(negedge clk);
      start_i = 1'b0;
      if (k < n - 1)
        check(beat_ready_o == 1'b1, "R4 ready held mid-run", beat_ready_o, 1);
    end
    beat_valid_i = 1'b0;
    check(beat_ready_o == 1'b0 && done_o == 1'b0, "R4 ready low after last beat",
          {beat_ready_o, done_o}, 0);
    @(negedge clk);
    check(done_o == 1'b0, "R9 no done one edge after last beat", done_o, 0);
    @(negedge clk);
    check(done_o == 1'b1, "R9 done two edges after last beat", done_o, 1);
    check(class_o == exp_cls, $sformatf("R5/R6/R7 class case %0d fails=%b", idx, fails),
          class_o, exp_cls);
    check(class_o != 2'b11, "R8 legal code", class_o, exp_cls);
    @(negedge clk);
    check(done_o == 1'b0 && class_o == exp_cls, "R9 single-cycle done, class held",
          {done_o, class_o}, {1'b0, exp_cls});
    check(busy_o == 1'b0, "R11 idle after run", busy_o, 0);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(class_o == 2'b00 && !done_o && !busy_o && !beat_ready_o, "R1 reset state",
          {class_o, done_o, busy_o, beat_ready_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: every pass/fail combination (R3, R5, R6, R7)
    for (int i = 0; i < 8; i++)
      run_case(i, 3 + i, VEC[i][4:2], VEC[i][1:0], 1'b0, 1'b0);

    // R3/R4: stalls between beats do not change the signature or the count
    run_case(20, 7, 3'b111, 2'b10, 1'b1, 1'b0);
    run_case(21, 6, 3'b000, 2'b00, 1'b1, 1'b0);

    // R4: zero length counts as one beat
    run_case(22, 0, 3'b110, 2'b01, 1'b0, 1'b0);

    // R10: start inside a run is ignored
    run_case(23, 5, 3'b101, 2'b01, 1'b0, 1'b1);

    // R11: beats offered while idle are not taken and do not disturb the next run
    beat_valid_i = 1'b1;
    beat_a_i = 16'h1234; beat_b_i = 16'h5678; beat_c_i = 16'h9ABC;
    repeat (3) begin
      @(negedge clk);
      check(beat_ready_o == 1'b0, "R11 ready low while idle", beat_ready_o, 0);
    end
    beat_valid_i = 1'b0;
    run_case(24, 4, 3'b000, 2'b00, 1'b0, 1'b0);

    // R9: class holds through a later run until its done
    gold_a_i = model_sig(0, 25, 4) ^ 16'h1;
    gold_b_i = model_sig(1, 25, 4) ^ 16'h1;
    gold_c_i = model_sig(2, 25, 4) ^ 16'h1;
    @(negedge clk); start_i = 1'b1; run_len_i = 8'd4;
    @(negedge clk); start_i = 1'b0;
    check(class_o == 2'b00, "R9 class held while next run starts", class_o, 0);
    for (int k = 0; k < 4; k++) begin
      beat_valid_i = 1'b1;
      beat_a_i = word(0, 25, k); beat_b_i = word(1, 25, k); beat_c_i = word(2, 25, k);
      @(negedge clk);
      check(class_o == 2'b00 && !done_o, "R9 class held during run", class_o, 0);
    end
    beat_valid_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(done_o && class_o == 2'b10, "R7 many after held run", {done_o, class_o}, 3'b110);
    @(negedge clk);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule